// File: doc/BRIEF.md
# Multi-Channel Register-Programmed PWM Generator

This block drives one pulse-width-modulated output for each of `NCH` channels. Each channel holds one 32-bit configuration word. The word sets a prescaler divisor, a duty count out of 256, a flag that forces the output fully on, and an enable. Software writes and reads the words through a simple single-cycle memory-mapped port. Address bits [5:4] select the channel.

Inside each channel, a prescaler divides the clock by the programmed value plus one, and an 8-bit counter counts the prescaled ticks. A period is therefore 256 ticks long. A small state machine decides the output level:

- **States:** `ST_OFF` (disabled, output low), `ST_HIGH` (output high) and `ST_LOW` (enabled, output low).
- **Write to the channel (every state):** goes to `ST_OFF` if the enable bit is clear. Otherwise it goes to `ST_HIGH` when the period should open active, and to `ST_LOW` when it should not. The counters restart from zero.
- **`ST_HIGH` to `ST_LOW` (duty reached):** taken on the tick where the count reaches the duty value, unless the force-full flag is set.
- **`ST_LOW` to `ST_HIGH` (period wrap):** taken on the tick where the count wraps to zero, if the duty is non-zero.

A disable or a reconfiguration takes effect at once; a period in progress is abandoned.

Top module: `pwm_bank`

## Requirements
- R1: After a synchronous active-low reset, every configuration word reads 0 and every output is low.
- R2: The word layout is: bits [12:0] prescaler value S, bits [23:16] duty D, bit 24 force-full F, bit 31 enable E. All other bits read as zero and ignore writes, so writing 0xFFFFFFFF reads back 0x81FF1FFF.
- R3: A write with `wr_en` high goes to channel `addr[5:4]` only. The configuration words and waveforms of the other channels stay unchanged.
- R4: While enabled with F clear, the output is periodic with 256*(S+1) clock cycles per period. It is high for the first D*(S+1) cycles of each period and low for the rest.
- R5: With E set, F clear and D = 0, the output stays low.
- R6: With E and F set, the output stays high whatever D holds.
- R7: Writing a word with E clear drives the output low from the first cycle after the write edge, even in the middle of a high phase.
- R8: Any write to a channel restarts its period at the write edge. In the cycle after the write the output is high when E is set and (F is set or D is non-zero), and low otherwise.
- R9: The output comes straight from a flip-flop and changes only at clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the PWM source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 6 | Byte address; bits [5:4] select the channel |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read of the word at `addr` |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The channel assertions assume that a configuration word changes only through a write to its own channel, in the same cycle as that channel's restart strobe. They also assume that `wr_en` is a single-cycle strobe sampled at the rising edge. The stimulus therefore changes `wr_en`, `addr` and `wdata` only at falling edges and always holds `wr_en` for one cycle. Full-period checks run from a known restart, so every expected level follows from the cycle count since the write.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int DATA_W    = 32;
    localparam int SCALE_W   = 13;
    localparam int DUTY_W    = 8;
    localparam int SCALE_LSB = 0;
    localparam int DUTY_LSB  = 16;
    localparam int FULL_BIT  = 24;
    localparam int EN_BIT    = 31;
    localparam int CH_STRIDE_LOG2 = 4;

    typedef struct packed {
        logic               en;
        logic               full;
        logic [DUTY_W-1:0]  duty;
        logic [SCALE_W-1:0] scale;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } ch_state_e;

    function automatic cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
        cfg_t c;
        c.en    = w[EN_BIT];
        c.full  = w[FULL_BIT];
        c.duty  = w[DUTY_LSB +: DUTY_W];
        c.scale = w[SCALE_LSB +: SCALE_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] word_from_cfg(input cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_BIT]                 = c.en;
        w[FULL_BIT]               = c.full;
        w[DUTY_LSB +: DUTY_W]     = c.duty;
        w[SCALE_LSB +: SCALE_W]   = c.scale;
        return w;
    endfunction

    function automatic logic opens_active(input cfg_t c);
        return c.en && (c.full || (c.duty != '0));
    endfunction
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int IDX_W  = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int ADDR_W = CH_STRIDE_LOG2 + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg_new,
    output cfg_t              cfg_q [NCH],
    output logic [NCH-1:0]    kick
);
    logic [IDX_W-1:0] idx;

    assign idx     = addr[CH_STRIDE_LOG2 +: IDX_W];
    assign cfg_new = cfg_from_word(wdata);

    for (genvar i = 0; i < NCH; i++) begin : g_word
        assign kick[i] = wr_en && (idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (kick[i]) begin
                cfg_q[i] <= cfg_new;
            end
        end

        // R3: a word changes only when its own channel is written
        a_r3_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            !kick[i] |=> $stable(cfg_q[i]));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (idx == IDX_W'(i)) rdata = word_from_cfg(cfg_q[i]);
        end
    end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  cfg_t cfg_new,
    input  cfg_t cfg_q,
    output logic pwm_o
);
    ch_state_e          state_q, state_d;
    logic [SCALE_W-1:0] pre_q;
    logic [DUTY_W-1:0]  cnt_q, cnt_nx;
    logic               tick;

    assign tick   = (pre_q == cfg_q.scale);
    assign cnt_nx = cnt_q + 1'b1;

    always_comb begin
        state_d = state_q;
        if (kick) begin
            if (!cfg_new.en)             state_d = ST_OFF;
            else if (opens_active(cfg_new)) state_d = ST_HIGH;
            else                         state_d = ST_LOW;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_OFF;
                ST_HIGH: if (tick && !cfg_q.full && (cnt_nx == cfg_q.duty))
                             state_d = ST_LOW;
                ST_LOW:  if (tick && (cnt_nx == '0) && (cfg_q.duty != '0))
                             state_d = ST_HIGH;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || kick || (state_q == ST_OFF)) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= cnt_nx;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_comb begin
        pwm_o = (state_q == ST_HIGH);
    end

    // R7: a write with the enable clear silences the output next cycle
    a_r7_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        kick && !cfg_new.en |=> !pwm_o);
    // R8: every write restarts both counters
    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (pre_q == '0) && (cnt_q == '0));
    // R6: force-full holds the output high
    a_r6_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        !kick && cfg_q.en && cfg_q.full |=> pwm_o);
    // R5: zero duty never goes high
    a_r5_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        !kick && cfg_q.en && !cfg_q.full && (cfg_q.duty == '0) |=> !pwm_o);
    // R4: the period counter advances only on prescaler ticks
    a_r4_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !kick && (state_q != ST_OFF) && !tick |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 4,
    localparam int IDX_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ADDR_W = CH_STRIDE_LOG2 + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    pwm_out
);
    cfg_t           cfg_new;
    cfg_t           cfg_q [NCH];
    logic [NCH-1:0] kick;

    pwm_bank_regs #(.NCH(NCH), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .cfg_new (cfg_new),
        .cfg_q   (cfg_q),
        .kick    (kick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        pwm_bank_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .kick    (kick[i]),
            .cfg_new (cfg_new),
            .cfg_q   (cfg_q[i]),
            .pwm_o   (pwm_out[i])
        );
    end
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
    localparam int NCH = 4;
    localparam logic [31:0] MASK = 32'h81FF_1FFF;
    localparam logic [31:0] EN   = 32'h8000_0000;
    localparam logic [31:0] FULL = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] pwm_out;

    pwm_bank #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    c;
        int    ch;
        logic  exp;
        string tag;
    } item_t;
    item_t sbq[$];

    logic [31:0] m_cfg [NCH];
    int          m_start [NCH];

    function automatic logic model(input int ch, input int c);
        logic [31:0] w;
        int k, t;
        w = m_cfg[ch];
        if (!w[31]) return 1'b0;
        if (w[24])  return 1'b1;
        k = c - m_start[ch] - 1;
        t = (k / (int'(w[12:0]) + 1)) % 256;
        return t < int'(w[23:16]);
    endfunction

    task automatic push(input int ch, input int len, input string tag);
        for (int i = 1; i <= len; i++) begin
            item_t it;
            it.c = cyc + i; it.ch = ch; it.exp = model(ch, cyc + i); it.tag = tag;
            sbq.push_back(it);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [31:0] d, input int len, input string tag);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = 6'(ch << 4);
        wdata = d;
        m_cfg[ch]   = d & MASK;
        m_start[ch] = cyc;
        push(ch, len, tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int ch, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = 6'(ch << 4);
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
    endtask

    // monitor: pops scoreboard items as the cycles they predict arrive
    always @(posedge clk) begin
        #5;
        while (sbq.size() > 0 && sbq[0].c <= cyc) begin
            item_t it;
            it = sbq.pop_front();
            n_chk++;
            if (it.c != cyc || pwm_out[it.ch] !== it.exp) begin
                n_fail++;
                $display("FAIL %s ch%0d cycle %0d: actual %b expected %b",
                         it.tag, it.ch, it.c, pwm_out[it.ch], it.exp);
            end
        end
    end

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin m_cfg[i] = '0; m_start[i] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < NCH; i++) rd(i, 32'h0, "R1 word after reset");
        chk("R1 outputs after reset", 32'(pwm_out), 32'h0);

        // R4: several duty and prescaler settings, R9 cycle-exact levels
        wr(0, EN | (32'd128 << 16), 600, "R4 R9 d128 s0"); drain();
        wr(0, EN | (32'd3 << 16) | 32'd2, 1600, "R4 d3 s2"); drain();
        wr(0, EN | (32'd1 << 16), 520, "R4 d1 s0"); drain();
        wr(0, EN | (32'd255 << 16), 520, "R4 d255 s0"); drain();
        // R5: zero duty
        wr(0, EN, 600, "R5 d0"); drain();
        // R6: force-full ignores duty
        wr(0, EN | FULL | (32'd5 << 16), 600, "R6 full d5"); drain();

        // R2: layout and masking of unused bits
        wr(2, 32'hFFFF_FFFF, 4, "R2 all ones"); drain();
        rd(2, MASK, "R2 readback mask");
        wr(3, EN | (32'd7 << 16) | 32'd9, 0, "R2 field"); 
        rd(3, EN | (32'd7 << 16) | 32'd9, "R2 field readback");
        rd(1, 32'h0, "R3 neighbour word untouched");

        // R7: disable in the middle of a high phase
        wr(0, EN | (32'd128 << 16), 60, "R7 pre"); drain();
        wr(0, (32'd128 << 16), 40, "R7 disable"); drain();
        rd(0, (32'd128 << 16), "R7 disabled readback");

        // R8: reconfigure during low phase, and rewrite during high phase
        wr(0, EN | (32'd100 << 16), 220, "R8 pre"); drain();
        wr(0, EN | (32'd10 << 16), 300, "R8 reconfig"); drain();
        wr(0, EN | (32'd200 << 16) | 32'd1, 100, "R8 pre2"); drain();
        wr(0, EN | (32'd200 << 16) | 32'd1, 600, "R8 rewrite"); drain();
        wr(0, EN, 3, "R8 opens low"); drain();

        // R3: writes to one channel leave the others running
        wr(1, EN | (32'd64 << 16) | 32'd1, 0, "R3 ch1");
        repeat (37) @(negedge clk);
        wr(3, EN | (32'd7 << 16), 300, "R3 ch3"); drain();
        push(1, 700, "R3 ch1 undisturbed");
        push(2, 0, "R3");
        drain();
        push(2, 50, "R3 ch2 undisturbed"); drain();
        push(0, 50, "R3 ch0 undisturbed"); drain();

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule